// File: doc/BRIEF.md
# Halfword Multiply-Accumulate Unit

This block multiplies two unsigned 16-bit halfwords taken from a pair of 32-bit operands and adds the product into a 64-bit accumulator. The accumulator is held as a high word and a low word. The low 32 bits of the new sum are returned as a result word, ready for writing to a destination register.

A mode input picks integer or fraction behaviour. In integer mode the lower halfwords are multiplied. In fraction mode the upper halfwords are multiplied and the product is doubled. A per-operation round flag folds a half-unit constant at bit 15 into the same 64-bit addition.

The accumulator can be read at any time. It can be cleared, and either of its words can be loaded directly. Each operation completes one cycle after it is issued. Operations may be issued on consecutive cycles, and each one builds on the sum left by the one before it.

Top module: `hmac_unit`

## Requirements
- R1: In integer mode (`frac_mode`=0), the product of `opnd_a[15:0]` and `opnd_b[15:0]` is formed as an unsigned value and added to the accumulator. Bits [31:16] of both operands have no effect in this mode.
- R2: In fraction mode (`frac_mode`=1), the unsigned product of `opnd_a[31:16]` and `opnd_b[31:16]` is shifted left by one bit before it is added. Bits [15:0] of both operands have no effect in this mode.
- R3: When `round_en`=1, the value 0x8000 is added into the same 64-bit sum. When `round_en`=0, nothing extra is added.
- R4: The new 64-bit sum is split across the two accumulator words: bits [63:32] go to `acc_hi` and bits [31:0] go to `acc_lo`. `res_data` carries bits [31:0] of that same sum.
- R5: The 64-bit sum wraps modulo 2^64. A carry out of the low word propagates into `acc_hi`, and a carry out of bit 63 is dropped.
- R6: `res_valid` is high for exactly the one cycle that follows each cycle with `in_valid`=1. The updated accumulator is visible on `acc_hi`/`acc_lo` in that same cycle.
- R7: When operations are issued on consecutive cycles, each one accumulates onto the result of the previous one.
- R8: `clr`=1 zeroes both accumulator words on the next cycle. It overrides any word load and any accumulate issued in the same cycle.
- R9: `hi_we`/`lo_we` load `hi_wdata`/`lo_wdata` into the corresponding word on the next cycle, and a word that is not loaded keeps its value. A load issued in the same cycle as an operation suppresses that operation's accumulator update. The operation still returns `res_valid` with a `res_data` computed from the old accumulator.
- R10: During and after reset, `acc_hi`, `acc_lo`, `res_data` and `res_valid` are all 0.
- R11: When there is no clear, no load and no operation, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Issue an operation this cycle |
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand |
| frac_mode | input | 1 | 0 = integer (low halves), 1 = fraction (high halves, product doubled) |
| round_en | input | 1 | Add the rounding constant 0x8000 |
| clr | input | 1 | Zero the accumulator |
| hi_we | input | 1 | Load the high accumulator word |
| hi_wdata | input | 32 | Data for the high word load |
| lo_we | input | 1 | Load the low accumulator word |
| lo_wdata | input | 32 | Data for the low word load |
| acc_hi | output | 32 | High accumulator word |
| acc_lo | output | 32 | Low accumulator word |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| res_data | output | 32 | Low 32 bits of the new sum |

## Verification
Every result is due exactly one clock edge after its stimulus. This applies to `res_valid`, `res_data`, the accumulate, the clear and the word loads. The bench drives inputs on the falling edge and checks the outputs on the next falling edge, which is half a cycle after the register that produces them has updated.

For back-to-back operations, the second operation is driven in the same falling-edge slot in which the first one's result is checked. This confirms that the second operation sees the first operation's sum one cycle later. A reference model of the 64-bit accumulator in the bench tracks every clear, load and operation, and supplies the expected value for each check.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  localparam int unsigned HMAC_DATA_W = 32;

  typedef enum logic [1:0] {
    ACC_HOLD  = 2'd0,
    ACC_CLEAR = 2'd1,
    ACC_LOAD  = 2'd2,
    ACC_ACCUM = 2'd3
  } acc_act_e;
endpackage

// File: rtl/hmac_rst_sync.sv
module hmac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        assign chain_d[gi] = 1'b1;
      end else begin : g_rest
        assign chain_d[gi] = chain_q[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hmac_prod.sv
module hmac_prod #(
  parameter int unsigned DATA_W = hmac_pkg::HMAC_DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              frac_i,
  output logic [DATA_W:0]   addend_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] a_half;
  logic [HALF_W-1:0] b_half;
  logic [DATA_W-1:0] prod;

  always_comb begin
    if (frac_i) begin
      a_half = a_i[DATA_W-1:HALF_W];
      b_half = b_i[DATA_W-1:HALF_W];
    end else begin
      a_half = a_i[HALF_W-1:0];
      b_half = b_i[HALF_W-1:0];
    end
    prod = DATA_W'(a_half) * DATA_W'(b_half);
    if (frac_i) addend_o = {prod, 1'b0};
    else        addend_o = {1'b0, prod};
  end
endmodule

// File: rtl/hmac_sum.sv
module hmac_sum #(
  parameter int unsigned DATA_W = hmac_pkg::HMAC_DATA_W
) (
  input  logic [2*DATA_W-1:0] acc_i,
  input  logic [DATA_W:0]     addend_i,
  input  logic                round_i,
  output logic [2*DATA_W-1:0] sum_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned ACC_W  = 2 * DATA_W;
  localparam logic [ACC_W-1:0] RND_K =
    {{(ACC_W-HALF_W){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};

  logic [ACC_W-1:0] addend_ext;
  logic [ACC_W-1:0] rnd_term;

  always_comb begin
    addend_ext = {{(ACC_W-DATA_W-1){1'b0}}, addend_i};
    rnd_term   = round_i ? RND_K : '0;
    sum_o      = acc_i + addend_ext + rnd_term;
  end
endmodule

// File: rtl/hmac_acc.sv
module hmac_acc #(
  parameter int unsigned DATA_W = hmac_pkg::HMAC_DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                hi_we_i,
  input  logic [DATA_W-1:0]   hi_wdata_i,
  input  logic                lo_we_i,
  input  logic [DATA_W-1:0]   lo_wdata_i,
  input  logic                accum_i,
  input  logic [2*DATA_W-1:0] sum_i,
  output logic [DATA_W-1:0]   hi_o,
  output logic [DATA_W-1:0]   lo_o
);
  import hmac_pkg::*;

  acc_act_e          act;
  logic [DATA_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic              acc_en;

  always_comb begin
    if (clr_i)                   act = ACC_CLEAR;
    else if (hi_we_i || lo_we_i) act = ACC_LOAD;
    else if (accum_i)            act = ACC_ACCUM;
    else                         act = ACC_HOLD;
  end

  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    acc_en = 1'b1;
    unique case (act)
      ACC_CLEAR: begin
        hi_d = '0;
        lo_d = '0;
      end
      ACC_LOAD: begin
        if (hi_we_i) hi_d = hi_wdata_i;
        if (lo_we_i) lo_d = lo_wdata_i;
      end
      ACC_ACCUM: begin
        hi_d = sum_i[2*DATA_W-1:DATA_W];
        lo_d = sum_i[DATA_W-1:0];
      end
      default: acc_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (acc_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (hi_q == '0 && lo_q == '0));
  a_r9_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && hi_we_i) |=> (hi_q == $past(hi_wdata_i)));
  a_r9_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && lo_we_i) |=> (lo_q == $past(lo_wdata_i)));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !hi_we_i && !lo_we_i && !accum_i) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/hmac_unit.sv
module hmac_unit #(
  parameter int unsigned DATA_W    = hmac_pkg::HMAC_DATA_W,
  parameter int unsigned RST_SYNCS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              frac_mode,
  input  logic              round_en,
  input  logic              clr,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] hi_wdata,
  input  logic              lo_we,
  input  logic [DATA_W-1:0] lo_wdata,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam int unsigned ACC_W = 2 * DATA_W;

  logic              rst_sync_n;
  logic [DATA_W:0]   addend;
  logic [ACC_W-1:0]  sum;
  logic [DATA_W-1:0] res_q, res_d;
  logic              vld_q;

  hmac_rst_sync #(.STAGES(RST_SYNCS)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hmac_prod #(.DATA_W(DATA_W)) u_prod (
    .a_i      (opnd_a),
    .b_i      (opnd_b),
    .frac_i   (frac_mode),
    .addend_o (addend)
  );

  hmac_sum #(.DATA_W(DATA_W)) u_sum (
    .acc_i    ({acc_hi, acc_lo}),
    .addend_i (addend),
    .round_i  (round_en),
    .sum_o    (sum)
  );

  hmac_acc #(.DATA_W(DATA_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (clr),
    .hi_we_i    (hi_we),
    .hi_wdata_i (hi_wdata),
    .lo_we_i    (lo_we),
    .lo_wdata_i (lo_wdata),
    .accum_i    (in_valid),
    .sum_i      (sum),
    .hi_o       (acc_hi),
    .lo_o       (acc_lo)
  );

  always_comb begin
    res_d = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= 1'b0;
    else             vld_q <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   res_q <= '0;
    else if (in_valid) res_q <= res_d;
  end

  assign res_valid = vld_q;
  assign res_data  = res_q;

  a_r6_done_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> res_valid);
  a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !res_valid);
  a_r4_result_matches_acc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !clr && !hi_we && !lo_we) |=> (res_data == acc_lo));
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (!res_valid && acc_hi == '0 && acc_lo == '0 && res_data == '0));
endmodule

// File: tb/sim_hmac_unit.sv
module sim_hmac_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, frac_mode, round_en, clr, hi_we, lo_we;
  logic [31:0] opnd_a, opnd_b, hi_wdata, lo_wdata;
  logic [31:0] acc_hi, acc_lo, res_data;
  logic        res_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;
  logic [63:0] m_acc;

  always #10 clk = ~clk;

  hmac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .frac_mode(frac_mode), .round_en(round_en), .clr(clr), .hi_we(hi_we),
    .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata), .acc_hi(acc_hi),
    .acc_lo(acc_lo), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [63:0] model(input logic [63:0] acc, input logic [31:0] a,
                                        input logic [31:0] b, input logic fr, input logic rn);
    logic [63:0] p;
    if (fr) p = 64'(a[31:16]) * 64'(b[31:16]) * 64'd2;
    else    p = 64'(a[15:0]) * 64'(b[15:0]);
    return acc + p + (rn ? 64'h8000 : 64'h0);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; clr = 0; hi_we = 0; lo_we = 0; round_en = 0; frac_mode = 0;
    opnd_a = '0; opnd_b = '0; hi_wdata = '0; lo_wdata = '0;
  endtask

  // issue one operation and check result one edge later
  task automatic do_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic fr, input logic rn);
    logic [63:0] e;
    @(negedge clk);
    in_valid = 1; opnd_a = a; opnd_b = b; frac_mode = fr; round_en = rn;
    e = model(m_acc, a, b, fr, rn);
    @(negedge clk);
    idle();
    m_acc = e;
    chk({tag, " R6 res_valid"}, 64'(res_valid), 64'd1);
    chk({tag, " R4 res_data"},  64'(res_data), 64'(e[31:0]));
    chk({tag, " R4 acc"},       {acc_hi, acc_lo}, e);
    @(negedge clk);
    chk({tag, " R6 strobe drops"}, 64'(res_valid), 64'd0);
  endtask

  task automatic load(input logic [63:0] v);
    @(negedge clk);
    hi_we = 1; lo_we = 1; hi_wdata = v[63:32]; lo_wdata = v[31:0];
    @(negedge clk);
    idle();
    m_acc = v;
    chk("R9 load both", {acc_hi, acc_lo}, v);
  endtask

  task automatic t_reset();
    chk("R10 reset acc", {acc_hi, acc_lo}, 64'd0);
    chk("R10 reset res", {31'd0, res_valid, res_data}, 64'd0);
  endtask

  task automatic t_integer();
    do_op("R1 int", 32'hABCD_0003, 32'h1234_0005, 1'b0, 1'b0);
    do_op("R1 int big", 32'h0000_FFFF, 32'h5555_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_fraction();
    load(64'd0);
    do_op("R2 frac", 32'h4000_1111, 32'h0003_2222, 1'b1, 1'b0);
    do_op("R2 frac max", 32'hFFFF_0001, 32'hFFFF_0001, 1'b1, 1'b0);
  endtask

  task automatic t_round();
    load(64'd0);
    do_op("R3 round int", 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b1);
    chk("R3 round const", {acc_hi, acc_lo}, 64'h8001);
    do_op("R3 round frac", 32'h0001_0000, 32'h7FFF_0000, 1'b1, 1'b1);
  endtask

  task automatic t_wrap();
    load(64'h0000_0000_FFFF_0000);
    do_op("R5 carry", 32'h0000_FFFF, 32'h0000_FFFF, 1'b0, 1'b0);
    chk("R5 carry hi", 64'(acc_hi), 64'd1);
    load(64'hFFFF_FFFF_FFFF_FFFF);
    do_op("R5 wrap", 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0);
    chk("R5 wrap zero", {acc_hi, acc_lo}, 64'd0);
  endtask

  task automatic t_b2b();
    logic [63:0] e1, e2;
    load(64'h10);
    @(negedge clk);
    in_valid = 1; opnd_a = 32'h0000_0100; opnd_b = 32'h0000_0010; frac_mode = 0; round_en = 0;
    e1 = model(m_acc, opnd_a, opnd_b, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 b2b first", 64'(res_data), 64'(e1[31:0]));
    opnd_a = 32'h0002_0000; opnd_b = 32'h0003_0000; frac_mode = 1; round_en = 1;
    e2 = model(e1, opnd_a, opnd_b, 1'b1, 1'b1);
    @(negedge clk);
    idle();
    m_acc = e2;
    chk("R7 b2b second res", 64'(res_data), 64'(e2[31:0]));
    chk("R7 b2b second acc", {acc_hi, acc_lo}, e2);
  endtask

  task automatic t_clear();
    load(64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    clr = 1; hi_we = 1; hi_wdata = 32'hDEAD_BEEF; in_valid = 1;
    opnd_a = 32'h0000_0002; opnd_b = 32'h0000_0003;
    @(negedge clk);
    idle();
    chk("R8 clear wins", {acc_hi, acc_lo}, 64'd0);
    chk("R8 op still done", 64'(res_valid), 64'd1);
    chk("R8 op res old acc", 64'(res_data), 64'(32'h9ABC_DEF0 + 32'd6));
    m_acc = 64'd0;
  endtask

  task automatic t_write_prio();
    load(64'h0000_0005_0000_0007);
    @(negedge clk);
    lo_we = 1; lo_wdata = 32'hCAFE_0000; in_valid = 1;
    opnd_a = 32'h0000_0004; opnd_b = 32'h0000_0004;
    @(negedge clk);
    idle();
    chk("R9 load beats op", {acc_hi, acc_lo}, 64'h0000_0005_CAFE_0000);
    chk("R9 op result old acc", 64'(res_data), 64'h17);
    m_acc = 64'h0000_0005_CAFE_0000;
    @(negedge clk);
    hi_we = 1; hi_wdata = 32'h0000_0042;
    @(negedge clk);
    idle();
    chk("R9 hi only, lo kept", {acc_hi, acc_lo}, 64'h0000_0042_CAFE_0000);
    m_acc = 64'h0000_0042_CAFE_0000;
  endtask

  task automatic t_hold();
    repeat (3) @(negedge clk);
    chk("R11 hold", {acc_hi, acc_lo}, m_acc);
    chk("R11 no strobe", 64'(res_valid), 64'd0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    m_acc = 64'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_integer();
    t_fraction();
    t_round();
    t_wrap();
    t_b2b();
    t_clear();
    t_write_prio();
    t_hold();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done_flag) begin
      done_flag = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule